// File: doc/BRIEF.md
# Receiver Polling Wake-Up Sequencer

This block is the control state machine of a low-power receiver that wakes up at intervals to listen for a transmitter. After a start command it runs through a fixed sequence: a sleep interval in which only the oscillator and this logic stay alive (SLEEP), PLL start-up (PLL_UP), start-up of the signal-processing chain (SIG_UP), and a bit-check window (BIT_CHK). In BIT_CHK an external checker reports pass or fail. A pass moves the machine into continuous reception (RECEIVE) and sets three control bits: data-output enable, clock-output enable and the hold-in-receive mode bit. A fail sends it back to SLEEP, or keeps it in BIT_CHK, depending on the mode bit and the configured sleep time.

The block is clocked at twice the rate of the receiver's basic clock, so every duration is counted in half basic periods. This lets the PLL phase last a fractional number of basic cycles. The transitions are: IDLE to SLEEP on start with a non-zero sleep time; IDLE to PLL_UP on start with a zero sleep time; SLEEP to PLL_UP and PLL_UP to SIG_UP when their timers expire; SIG_UP to BIT_CHK when its timer expires; BIT_CHK to RECEIVE on a pass; BIT_CHK to SLEEP on a qualifying fail. An idle command takes the machine from any state back to IDLE, which is the way out of RECEIVE after the FSK demodulator has lost lock.

Top module: `rx_poll_seq`

## Requirements
- R1: After a synchronous reset, state_o is IDLE (code 0) and rx_active, en_pll, en_sigproc, en_bitchk, data_out_en, clk_out_en, hold_rx and data_out are all 0.
- R2: SLEEP (code 1) lasts cfg_sleep × SLEEP_UNIT × 2 clock cycles, times 8 when cfg_sleep_ext is 1. During SLEEP, rx_active, en_pll, en_sigproc and en_bitchk are 0.
- R3: PLL_UP (code 2) lasts PLL_HALF clock cycles (default 1597, which is 798.5 basic cycles). From PLL_UP through RECEIVE, en_pll and rx_active are 1.
- R4: SIG_UP (code 3) lasts 2 × SP_Rn clock cycles, where n is cfg_baud (defaults 882, 498, 306 and 210 basic cycles for n = 0 to 3). en_sigproc is 1 from SIG_UP through RECEIVE.
- R5: en_bitchk is 1 only in BIT_CHK (code 4). A chk_pass there moves the machine to RECEIVE (code 5) on the next cycle and sets data_out_en, clk_out_en and hold_rx to 1.
- R6: A chk_fail in BIT_CHK, without chk_pass, returns the machine to SLEEP when hold_rx is 0 and the configured sleep time is non-zero. The new sleep again lasts the R2 duration.
- R7: A chk_fail in BIT_CHK with hold_rx at 1 or a zero sleep time leaves the machine in BIT_CHK.
- R8: RECEIVE is left only through idle_cmd: chk_pass and chk_fail have no effect there. In RECEIVE, data_out follows demod_in; in every other state data_out is 0.
- R9: idle_cmd in any state other than IDLE moves the machine to IDLE on the next cycle and clears data_out_en, clk_out_en and hold_rx.
- R10: start_poll in IDLE loads hold_rx from cfg_hold_rx. With cfg_sleep at 0 the machine goes directly to PLL_UP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the basic clock rate |
| rst | input | 1 | Synchronous reset, active high |
| start_poll | input | 1 | Starts a polling cycle from IDLE |
| idle_cmd | input | 1 | Forces the machine to IDLE |
| cfg_sleep | input | 5 | Sleep count in units of SLEEP_UNIT basic cycles |
| cfg_sleep_ext | input | 1 | Multiplies the sleep time by 8 |
| cfg_baud | input | 2 | Baud-range select for the signal-processing start-up time |
| cfg_hold_rx | input | 1 | Initial value of the hold-in-receive mode bit |
| chk_pass | input | 1 | Bit-check pass pulse |
| chk_fail | input | 1 | Bit-check fail pulse |
| demod_in | input | 1 | Demodulated data stream |
| state_o | output | 3 | Current state code |
| rx_active | output | 1 | High outside IDLE and SLEEP |
| en_pll | output | 1 | PLL enable |
| en_sigproc | output | 1 | Signal-processing enable |
| en_bitchk | output | 1 | Bit-checker enable |
| data_out_en | output | 1 | Data-output enable control bit |
| clk_out_en | output | 1 | Clock-output enable control bit |
| hold_rx | output | 1 | Hold-in-receive mode bit |
| data_out | output | 1 | Received data output |

## Verification
A vector table sweeps combinations of sleep count, extension bit and baud range, including a zero sleep count. The bench measures how long each phase lasts, which tells the four baud-dependent start-up times apart and shows whether the ×8 extension and the sleep bypass work. Directed runs then send fail pulses with the mode bit clear and set, and with a zero sleep time, to separate the return-to-sleep path from the stay-in-check path. Further runs show that check pulses have no effect in RECEIVE, that data reaches the output only in RECEIVE, and that the idle command clears the control bits from both SLEEP and RECEIVE.

// File: rtl/rx_poll_pkg.sv
package rx_poll_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SLEEP   = 3'd1,
        ST_PLL_UP  = 3'd2,
        ST_SIG_UP  = 3'd3,
        ST_BIT_CHK = 3'd4,
        ST_RECEIVE = 3'd5
    } poll_state_e;
endpackage

// File: rtl/rx_poll_dur.sv
module rx_poll_dur #(
    parameter int SLEEP_UNIT = 1024,
    parameter int PLL_HALF   = 1597,
    parameter int SP_R0      = 882,
    parameter int SP_R1      = 498,
    parameter int SP_R2      = 306,
    parameter int SP_R3      = 210,
    parameter int CW         = 20
) (
    input  logic [4:0]    cfg_sleep,
    input  logic          cfg_sleep_ext,
    input  logic [1:0]    cfg_baud,
    output logic [CW-1:0] sleep_half,
    output logic [CW-1:0] pll_half,
    output logic [CW-1:0] sig_half,
    output logic          sleep_zero
);
    localparam int NRANGE = 4;
    localparam int SP_TAB [NRANGE] = '{SP_R0, SP_R1, SP_R2, SP_R3};

    logic [CW-1:0] sig_tab [NRANGE];
    logic [CW-1:0] sleep_base;

    for (genvar g = 0; g < NRANGE; g++) begin : g_sig
        assign sig_tab[g] = CW'(2 * SP_TAB[g]);
    end

    always_comb begin
        sleep_base = CW'(cfg_sleep) * CW'(2 * SLEEP_UNIT);
        sleep_half = cfg_sleep_ext ? (sleep_base << 3) : sleep_base;
    end

    assign pll_half   = CW'(PLL_HALF);
    assign sig_half   = sig_tab[cfg_baud];
    assign sleep_zero = (cfg_sleep == 5'd0);
endmodule

// File: rtl/rx_poll_timer.sv
module rx_poll_timer #(
    parameter int CW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // R2: a running count falls by one each cycle unless reloaded
    p_tick_down_r2: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/rx_poll_fsm.sv
module rx_poll_fsm
    import rx_poll_pkg::*;
#(
    parameter int CW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_poll,
    input  logic          idle_cmd,
    input  logic          cfg_hold_rx,
    input  logic          chk_pass,
    input  logic          chk_fail,
    input  logic          demod_in,
    input  logic [CW-1:0] sleep_half,
    input  logic [CW-1:0] pll_half,
    input  logic [CW-1:0] sig_half,
    input  logic          sleep_zero,
    input  logic          t_expired,
    output logic          t_load,
    output logic [CW-1:0] t_val,
    output poll_state_e   state,
    output logic          rx_active,
    output logic          en_pll,
    output logic          en_sigproc,
    output logic          en_bitchk,
    output logic          data_out_en,
    output logic          clk_out_en,
    output logic          hold_rx,
    output logic          data_out
);
    poll_state_e state_nx;
    logic        set_bits;
    logic        clr_bits;
    logic        take_hold;

    always_comb begin
        state_nx  = state;
        t_load    = 1'b0;
        t_val     = '0;
        set_bits  = 1'b0;
        clr_bits  = 1'b0;
        take_hold = 1'b0;
        if (idle_cmd && state != ST_IDLE) begin
            state_nx = ST_IDLE;
            clr_bits = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_poll) begin
                        take_hold = 1'b1;
                        t_load    = 1'b1;
                        if (sleep_zero) begin
                            state_nx = ST_PLL_UP;
                            t_val    = pll_half - 1'b1;
                        end else begin
                            state_nx = ST_SLEEP;
                            t_val    = sleep_half - 1'b1;
                        end
                    end
                end
                ST_SLEEP: begin
                    if (t_expired) begin
                        state_nx = ST_PLL_UP;
                        t_load   = 1'b1;
                        t_val    = pll_half - 1'b1;
                    end
                end
                ST_PLL_UP: begin
                    if (t_expired) begin
                        state_nx = ST_SIG_UP;
                        t_load   = 1'b1;
                        t_val    = sig_half - 1'b1;
                    end
                end
                ST_SIG_UP: begin
                    if (t_expired) begin
                        state_nx = ST_BIT_CHK;
                    end
                end
                ST_BIT_CHK: begin
                    if (chk_pass) begin
                        state_nx = ST_RECEIVE;
                        set_bits = 1'b1;
                    end else if (chk_fail && !hold_rx && !sleep_zero) begin
                        state_nx = ST_SLEEP;
                        t_load   = 1'b1;
                        t_val    = sleep_half - 1'b1;
                    end
                end
                ST_RECEIVE: begin
                    state_nx = ST_RECEIVE;
                end
                default: begin
                    state_nx = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            data_out_en <= 1'b0;
            clk_out_en  <= 1'b0;
            hold_rx     <= 1'b0;
        end else begin
            state <= state_nx;
            if (clr_bits) begin
                data_out_en <= 1'b0;
                clk_out_en  <= 1'b0;
                hold_rx     <= 1'b0;
            end else if (set_bits) begin
                data_out_en <= 1'b1;
                clk_out_en  <= 1'b1;
                hold_rx     <= 1'b1;
            end else if (take_hold) begin
                hold_rx <= cfg_hold_rx;
            end
        end
    end

    always_comb begin
        rx_active  = 1'b0;
        en_pll     = 1'b0;
        en_sigproc = 1'b0;
        en_bitchk  = 1'b0;
        data_out   = 1'b0;
        unique case (state)
            ST_IDLE, ST_SLEEP: begin
                rx_active = 1'b0;
            end
            ST_PLL_UP: begin
                rx_active = 1'b1;
                en_pll    = 1'b1;
            end
            ST_SIG_UP: begin
                rx_active  = 1'b1;
                en_pll     = 1'b1;
                en_sigproc = 1'b1;
            end
            ST_BIT_CHK: begin
                rx_active  = 1'b1;
                en_pll     = 1'b1;
                en_sigproc = 1'b1;
                en_bitchk  = 1'b1;
            end
            ST_RECEIVE: begin
                rx_active  = 1'b1;
                en_pll     = 1'b1;
                en_sigproc = 1'b1;
                data_out   = demod_in & data_out_en;
            end
            default: begin
                rx_active = 1'b0;
            end
        endcase
    end

    p_sleep_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP) |-> (!rx_active && !en_pll && !en_sigproc && !en_bitchk));

    p_pass_rx_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BIT_CHK && chk_pass && !idle_cmd)
        |=> (state == ST_RECEIVE && data_out_en && clk_out_en && hold_rx));

    p_fail_sleep_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BIT_CHK && chk_fail && !chk_pass && !idle_cmd && !hold_rx && !sleep_zero)
        |=> (state == ST_SLEEP));

    p_fail_stay_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BIT_CHK && chk_fail && !chk_pass && !idle_cmd && (hold_rx || sleep_zero))
        |=> (state == ST_BIT_CHK));

    p_rx_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RECEIVE && !idle_cmd) |=> (state == ST_RECEIVE));

    p_idle_cmd_r9: assert property (@(posedge clk) disable iff (rst)
        idle_cmd |=> (state == ST_IDLE && !data_out_en && !clk_out_en && !hold_rx));
endmodule

// File: rtl/rx_poll_seq.sv
module rx_poll_seq
    import rx_poll_pkg::*;
#(
    parameter int SLEEP_UNIT = 1024,
    parameter int PLL_HALF   = 1597,
    parameter int SP_R0      = 882,
    parameter int SP_R1      = 498,
    parameter int SP_R2      = 306,
    parameter int SP_R3      = 210
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_poll,
    input  logic       idle_cmd,
    input  logic [4:0] cfg_sleep,
    input  logic       cfg_sleep_ext,
    input  logic [1:0] cfg_baud,
    input  logic       cfg_hold_rx,
    input  logic       chk_pass,
    input  logic       chk_fail,
    input  logic       demod_in,
    output logic [2:0] state_o,
    output logic       rx_active,
    output logic       en_pll,
    output logic       en_sigproc,
    output logic       en_bitchk,
    output logic       data_out_en,
    output logic       clk_out_en,
    output logic       hold_rx,
    output logic       data_out
);
    localparam int SLEEP_W = 5 + $clog2(SLEEP_UNIT) + 5;
    localparam int CW      = (SLEEP_W > 16) ? SLEEP_W : 16;

    logic [CW-1:0] sleep_half;
    logic [CW-1:0] pll_half;
    logic [CW-1:0] sig_half;
    logic          sleep_zero;
    logic          t_load;
    logic [CW-1:0] t_val;
    logic          t_expired;
    poll_state_e   state;

    rx_poll_dur #(
        .SLEEP_UNIT (SLEEP_UNIT),
        .PLL_HALF   (PLL_HALF),
        .SP_R0      (SP_R0),
        .SP_R1      (SP_R1),
        .SP_R2      (SP_R2),
        .SP_R3      (SP_R3),
        .CW         (CW)
    ) i_dur (
        .cfg_sleep     (cfg_sleep),
        .cfg_sleep_ext (cfg_sleep_ext),
        .cfg_baud      (cfg_baud),
        .sleep_half    (sleep_half),
        .pll_half      (pll_half),
        .sig_half      (sig_half),
        .sleep_zero    (sleep_zero)
    );

    rx_poll_timer #(.CW(CW)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    rx_poll_fsm #(.CW(CW)) i_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_poll  (start_poll),
        .idle_cmd    (idle_cmd),
        .cfg_hold_rx (cfg_hold_rx),
        .chk_pass    (chk_pass),
        .chk_fail    (chk_fail),
        .demod_in    (demod_in),
        .sleep_half  (sleep_half),
        .pll_half    (pll_half),
        .sig_half    (sig_half),
        .sleep_zero  (sleep_zero),
        .t_expired   (t_expired),
        .t_load      (t_load),
        .t_val       (t_val),
        .state       (state),
        .rx_active   (rx_active),
        .en_pll      (en_pll),
        .en_sigproc  (en_sigproc),
        .en_bitchk   (en_bitchk),
        .data_out_en (data_out_en),
        .clk_out_en  (clk_out_en),
        .hold_rx     (hold_rx),
        .data_out    (data_out)
    );

    assign state_o = state;
endmodule

// File: tb/test_rx_poll_seq.sv
module test_rx_poll_seq;
    localparam int CLK_PERIOD = 10;
    localparam int UNIT  = 4;
    localparam int PLLH  = 7;
    localparam int SP_TB [4] = '{20, 12, 7, 4};
    localparam int NVEC  = 5;
    // sleep, ext, baud
    localparam int VEC [NVEC][3] = '{
        '{1, 0, 0}, '{2, 0, 1}, '{1, 1, 2}, '{0, 0, 3}, '{3, 1, 0}};

    localparam logic [2:0] S_IDLE = 3'd0, S_SLEEP = 3'd1, S_PLL = 3'd2,
                           S_SIG = 3'd3, S_CHK = 3'd4, S_RX = 3'd5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_poll = 1'b0, idle_cmd = 1'b0;
    logic [4:0] cfg_sleep = '0;
    logic cfg_sleep_ext = 1'b0;
    logic [1:0] cfg_baud = '0;
    logic cfg_hold_rx = 1'b0;
    logic chk_pass = 1'b0, chk_fail = 1'b0, demod_in = 1'b0;
    logic [2:0] state_o;
    logic rx_active, en_pll, en_sigproc, en_bitchk;
    logic data_out_en, clk_out_en, hold_rx, data_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int n_sl, n_pll, n_sig;
    bit bad_sl, bad_act;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_poll_seq #(
        .SLEEP_UNIT(UNIT), .PLL_HALF(PLLH),
        .SP_R0(SP_TB[0]), .SP_R1(SP_TB[1]), .SP_R2(SP_TB[2]), .SP_R3(SP_TB[3])
    ) i_rx_poll_seq (
        .clk(clk), .rst(rst), .start_poll(start_poll), .idle_cmd(idle_cmd),
        .cfg_sleep(cfg_sleep), .cfg_sleep_ext(cfg_sleep_ext), .cfg_baud(cfg_baud),
        .cfg_hold_rx(cfg_hold_rx), .chk_pass(chk_pass), .chk_fail(chk_fail),
        .demod_in(demod_in), .state_o(state_o), .rx_active(rx_active),
        .en_pll(en_pll), .en_sigproc(en_sigproc), .en_bitchk(en_bitchk),
        .data_out_en(data_out_en), .clk_out_en(clk_out_en), .hold_rx(hold_rx),
        .data_out(data_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start_poll = 0; idle_cmd = 0; chk_pass = 0; chk_fail = 0; demod_in = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic start_run(input int sl, input int ext, input int baud, input bit hold);
        cfg_sleep = 5'(sl); cfg_sleep_ext = ext[0]; cfg_baud = 2'(baud); cfg_hold_rx = hold;
        start_poll = 1'b1;
        @(negedge clk);
        start_poll = 1'b0;
    endtask

    // samples once per negedge from the current one until BIT_CHK is seen
    task automatic run_to_chk();
        n_sl = 0; n_pll = 0; n_sig = 0; bad_sl = 0; bad_act = 0;
        for (int k = 0; k < 20000 && state_o != S_CHK; k++) begin
            if (state_o == S_SLEEP) begin
                n_sl++;
                if (rx_active || en_pll || en_sigproc || en_bitchk) bad_sl = 1;
            end else if (state_o == S_PLL) begin
                n_pll++;
                if (!rx_active || !en_pll || en_sigproc || en_bitchk) bad_act = 1;
            end else if (state_o == S_SIG) begin
                n_sig++;
                if (!rx_active || !en_pll || !en_sigproc || en_bitchk) bad_act = 1;
            end
            @(negedge clk);
        end
    endtask

    task automatic pulse(input bit pass, input bit fail);
        chk_pass = pass; chk_fail = fail;
        @(negedge clk);
        chk_pass = 0; chk_fail = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check(state_o == S_IDLE, "R1 state", int'(state_o), 0);
        check({rx_active, en_pll, en_sigproc, en_bitchk, data_out_en, clk_out_en, hold_rx, data_out} == 8'd0,
              "R1 outputs", int'({rx_active, en_pll, en_sigproc, en_bitchk, data_out_en, clk_out_en, hold_rx, data_out}), 0);

        // table walk: phase durations (R2, R3, R4, R10), pass into receive (R5)
        for (int v = 0; v < NVEC; v++) begin
            int exp_sl;
            do_reset();
            exp_sl = VEC[v][0] * UNIT * 2 * (VEC[v][1] != 0 ? 8 : 1);
            start_run(VEC[v][0], VEC[v][1], VEC[v][2], 1'b0);
            run_to_chk();
            check(n_sl == exp_sl, "R2 sleep length", n_sl, exp_sl);
            check(!bad_sl, "R2 sleep outputs", int'(bad_sl), 0);
            check(n_pll == PLLH, "R3 pll length", n_pll, PLLH);
            check(n_sig == 2 * SP_TB[VEC[v][2]], "R4 sigproc length", n_sig, 2 * SP_TB[VEC[v][2]]);
            check(!bad_act, "R3 R4 enables", int'(bad_act), 0);
            check(en_bitchk && rx_active, "R5 bitchk enable", int'(en_bitchk), 1);
            pulse(1'b1, 1'b0);
            check(state_o == S_RX, "R5 to receive", int'(state_o), 5);
            check(data_out_en && clk_out_en && hold_rx && !en_bitchk, "R5 control bits",
                  int'({data_out_en, clk_out_en, hold_rx, en_bitchk}), 14);
        end

        // R6: fail with mode bit clear and sleep > 0 returns to sleep of full length
        do_reset();
        start_run(1, 0, 3, 1'b0);
        run_to_chk();
        pulse(1'b0, 1'b1);
        check(state_o == S_SLEEP, "R6 fail to sleep", int'(state_o), 1);
        run_to_chk();
        check(n_sl == UNIT * 2, "R6 resleep length", n_sl, UNIT * 2);

        // R7: fail with mode bit set stays in bit check; R10 hold loaded from config
        do_reset();
        start_run(1, 0, 3, 1'b1);
        check(hold_rx == 1'b1, "R10 hold loaded", int'(hold_rx), 1);
        run_to_chk();
        pulse(1'b0, 1'b1);
        check(state_o == S_CHK, "R7 stay with hold", int'(state_o), 4);

        // R7: fail with zero sleep time stays in bit check
        do_reset();
        start_run(0, 0, 3, 1'b0);
        check(state_o == S_PLL, "R10 skip sleep", int'(state_o), 2);
        run_to_chk();
        pulse(1'b0, 1'b1);
        check(state_o == S_CHK, "R7 stay zero sleep", int'(state_o), 4);

        // R8: receive ignores check pulses; data only in receive
        demod_in = 1'b1; #1;
        check(data_out == 1'b0, "R8 no data in bitchk", int'(data_out), 0);
        pulse(1'b1, 1'b0);
        demod_in = 1'b1; #1;
        check(data_out == 1'b1, "R8 data high", int'(data_out), 1);
        demod_in = 1'b0; #1;
        check(data_out == 1'b0, "R8 data low", int'(data_out), 0);
        @(negedge clk);
        pulse(1'b0, 1'b1);
        check(state_o == S_RX, "R8 fail ignored", int'(state_o), 5);
        pulse(1'b1, 1'b0);
        check(state_o == S_RX, "R8 pass ignored", int'(state_o), 5);

        // R9: idle command from receive clears bits
        idle_cmd = 1'b1;
        @(negedge clk);
        idle_cmd = 1'b0;
        check(state_o == S_IDLE, "R9 idle from rx", int'(state_o), 0);
        check({data_out_en, clk_out_en, hold_rx} == 3'b000, "R9 bits cleared",
              int'({data_out_en, clk_out_en, hold_rx}), 0);

        // R9: idle command from sleep
        start_run(2, 1, 0, 1'b1);
        check(state_o == S_SLEEP, "R9 in sleep", int'(state_o), 1);
        idle_cmd = 1'b1;
        @(negedge clk);
        idle_cmd = 1'b0;
        check(state_o == S_IDLE && !hold_rx, "R9 idle from sleep", int'(state_o), 0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule